// File: doc/BRIEF.md
# Watermark Flow Controller for Channelised FIFOs

This block tracks the fill level of four FIFOs in each of several channels: inbound data, inbound control, outbound data and outbound control. It does not hold the FIFO storage. It counts the write and read events the FIFOs accept. Each count is compared with a programmable pair of 8-bit marks, a high one and a low one, and the result is a near-full flag with hysteresis. The flag turns on at the high mark and turns off only once the level has fallen to the low mark.

On the outbound side, either near-full flag of a channel withdraws that channel's `ready`. Local senders must hold off while `ready` is low. On the inbound side, either near-full flag raises `pause`, which asks the far end to stop sending. A write into a full FIFO gives a one-cycle overflow pulse, and a read from an empty one gives a one-cycle underflow pulse. A per-channel flush empties all four counts.

The `push` and `pop` strobes are completed handshakes: each one means a beat was accepted (valid and ready) by the FIFO on that cycle. `ready` is back-pressure toward outbound senders. A beat pushed while `ready` is low is still counted, because the FIFO may have taken it. Only a write into a full FIFO is flagged.

Top module: `fcw_flow_ctl`

## Requirements
- R1: After reset all occupancies are zero, every `near_full`, `ovf_err` and `unf_err` bit is 0, every `ready` is 1 and every `pause` is 0.
- R2: A push alone raises a FIFO's occupancy by one, but not beyond DEPTH. A pop alone lowers it by one, but not below zero. A push and a pop in the same cycle leave it unchanged and report no error.
- R3: At each clock edge, if the occupancy held before the edge is at or above the high mark, `near_full` is 1 after that edge. A push is therefore seen in `near_full` two edges later.
- R4: Otherwise, if that occupancy is at or below the low mark, `near_full` becomes 0. Between the two marks it keeps its value. When both marks match, setting wins.
- R5: `ready[c]` is 0 whenever the outbound data flag (q=2) or the outbound control flag (q=3) of channel c is 1.
- R6: `pause[c]` is 1 exactly when the inbound data flag (q=0) or the inbound control flag (q=1) of channel c is 1.
- R7: A push without a pop while the occupancy equals DEPTH gives `ovf_err` = 1 for the one cycle after that edge. The occupancy stays at DEPTH.
- R8: A pop without a push while the occupancy is zero gives `unf_err` = 1 for the one cycle after that edge.
- R9: While `flush[c]` is sampled high, the four occupancies of channel c go to zero and its flags and error bits go to 0. Its `ready` is 0 from the edge after flush is first sampled. `ready` returns to 1 at the first edge that samples flush low.
- R10: Channels are independent. FIFO q of channel c uses bit c*4+q of `push`, `pop`, `near_full`, `ovf_err` and `unf_err`, and bits (c*4+q)*8 upward of `wm_lo` and `wm_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | NUM_CH*4 | Accepted write beat per FIFO |
| pop | input | NUM_CH*4 | Accepted read beat per FIFO |
| flush | input | NUM_CH | Hold high to empty a channel |
| wm_lo | input | NUM_CH*4*8 | Low (release) mark per FIFO |
| wm_hi | input | NUM_CH*4*8 | High (assert) mark per FIFO |
| near_full | output | NUM_CH*4 | Hysteretic near-full flag per FIFO |
| ready | output | NUM_CH | Outbound senders may send |
| pause | output | NUM_CH | Request to the far end to stop inbound traffic |
| ovf_err | output | NUM_CH*4 | One-cycle write-while-full pulse |
| unf_err | output | NUM_CH*4 | One-cycle read-while-empty pulse |

## Verification
The bench fills every FIFO past DEPTH and then drains it past empty, once for each of several mark pairs. The pairs include a zero low mark, a high mark equal to DEPTH, equal marks and inverted marks.

Each of these cases catches a different mistake:
- A design that compared with strict inequality, or tested the marks in the wrong order, would flip the flag one level late or lose the set-wins rule.
- A design that wrapped the count instead of saturating would drop the flag after an overflow.
- A design that treated a same-cycle push and pop at an empty FIFO as an underflow would raise a false `unf_err`.
- A design that released `ready` on the flush edge itself, or let flush leave a stale flag, would show up in the flush sequence.

A long mixed run on both channels catches any crossing of bit slices between channels.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
  localparam int QPC = 4;
  typedef enum logic [1:0] {
    Q_IN_DATA  = 2'd0,
    Q_IN_CTRL  = 2'd1,
    Q_OUT_DATA = 2'd2,
    Q_OUT_CTRL = 2'd3
  } fcw_queue_e;
endpackage

// File: rtl/fcw_occ.sv
module fcw_occ #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] occ,
  output logic          ovf,
  output logic          unf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic up, dn;
  assign up = push & ~pop;
  assign dn = pop & ~push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (flush) begin
      occ <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= up && (occ == FULL);
      unf <= dn && (occ == '0);
      if (up && occ != FULL)
        occ <= occ + 1'b1;
      else if (dn && occ != '0)
        occ <= occ - 1'b1;
    end
  end
endmodule

// File: rtl/fcw_mark.sv
module fcw_mark #(
  parameter int CW   = 9,
  parameter int WM_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [CW-1:0]   occ,
  input  logic [WM_W-1:0] lo,
  input  logic [WM_W-1:0] hi,
  output logic            nf
);
  localparam int MW = (CW > WM_W) ? CW : WM_W;

  logic [MW-1:0] occ_x, lo_x, hi_x;
  assign occ_x = MW'(occ);
  assign lo_x  = MW'(lo);
  assign hi_x  = MW'(hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      nf <= 1'b0;
    else if (flush)
      nf <= 1'b0;
    else if (occ_x >= hi_x)
      nf <= 1'b1;
    else if (occ_x <= lo_x)
      nf <= 1'b0;
  end
endmodule

// File: rtl/fcw_channel.sv
module fcw_channel
  import fcw_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WM_W  = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [QPC-1:0]      push,
  input  logic [QPC-1:0]      pop,
  input  logic [QPC*WM_W-1:0] wm_lo,
  input  logic [QPC*WM_W-1:0] wm_hi,
  output logic [QPC-1:0]      near_full,
  output logic                ready,
  output logic                pause,
  output logic [QPC-1:0]      ovf_err,
  output logic [QPC-1:0]      unf_err
);
  logic flush_q;

  for (genvar q = 0; q < QPC; q++) begin : g_q
    logic [CW-1:0] occ;

    fcw_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (push[q]),
      .pop   (pop[q]),
      .occ   (occ),
      .ovf   (ovf_err[q]),
      .unf   (unf_err[q])
    );

    fcw_mark #(.CW(CW), .WM_W(WM_W)) u_mark (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .occ   (occ),
      .lo    (wm_lo[q*WM_W +: WM_W]),
      .hi    (wm_hi[q*WM_W +: WM_W]),
      .nf    (near_full[q])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush;
  end

  assign ready = ~flush_q & ~near_full[int'(Q_OUT_DATA)] & ~near_full[int'(Q_OUT_CTRL)];
  assign pause = near_full[int'(Q_IN_DATA)] | near_full[int'(Q_IN_CTRL)];
endmodule

// File: rtl/fcw_flow_ctl.sv
module fcw_flow_ctl #(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 256,
  parameter int WM_W   = 8,
  localparam int QN    = NUM_CH * fcw_pkg::QPC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [QN-1:0]      push,
  input  logic [QN-1:0]      pop,
  input  logic [NUM_CH-1:0]  flush,
  input  logic [QN*WM_W-1:0] wm_lo,
  input  logic [QN*WM_W-1:0] wm_hi,
  output logic [QN-1:0]      near_full,
  output logic [NUM_CH-1:0]  ready,
  output logic [NUM_CH-1:0]  pause,
  output logic [QN-1:0]      ovf_err,
  output logic [QN-1:0]      unf_err
);
  localparam int Q = fcw_pkg::QPC;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fcw_channel #(.DEPTH(DEPTH), .WM_W(WM_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush[c]),
      .push      (push[c*Q +: Q]),
      .pop       (pop[c*Q +: Q]),
      .wm_lo     (wm_lo[c*Q*WM_W +: Q*WM_W]),
      .wm_hi     (wm_hi[c*Q*WM_W +: Q*WM_W]),
      .near_full (near_full[c*Q +: Q]),
      .ready     (ready[c]),
      .pause     (pause[c]),
      .ovf_err   (ovf_err[c*Q +: Q]),
      .unf_err   (unf_err[c*Q +: Q])
    );
  end
endmodule

// File: rtl/fcw_flow_ctl_chk.sv
module fcw_flow_ctl_chk #(
  parameter int NUM_CH = 2,
  localparam int QN    = NUM_CH * 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [QN-1:0]     push,
  input logic [QN-1:0]     pop,
  input logic [NUM_CH-1:0] flush,
  input logic [QN-1:0]     near_full,
  input logic [NUM_CH-1:0] ready,
  input logic [NUM_CH-1:0] pause,
  input logic [QN-1:0]     ovf_err,
  input logic [QN-1:0]     unf_err
);
  for (genvar b = 0; b < QN; b++) begin : g_b
    p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err[b] |-> $past(push[b] && !pop[b] && !flush[b/4]));
    p_unf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      unf_err[b] |-> $past(pop[b] && !push[b] && !flush[b/4]));
    p_err_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_err[b] && unf_err[b]));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush[c]) |-> (!ready[c] && near_full[c*4 +: 4] == 4'b0 &&
                           ovf_err[c*4 +: 4] == 4'b0 && unf_err[c*4 +: 4] == 4'b0));
    p_ready_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ready[c] |-> (!near_full[c*4+2] && !near_full[c*4+3]));
    p_pause_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pause[c]) |-> !$past(flush[c]));
  end
endmodule

bind fcw_flow_ctl fcw_flow_ctl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push      (push),
  .pop       (pop),
  .flush     (flush),
  .near_full (near_full),
  .ready     (ready),
  .pause     (pause),
  .ovf_err   (ovf_err),
  .unf_err   (unf_err)
);

// File: tb/sim_fcw_flow_ctl.sv
`timescale 1ns/1ps
module sim_fcw_flow_ctl;
  localparam int NCH = 2;
  localparam int DEP = 16;
  localparam int W   = 8;
  localparam int QN  = NCH * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [QN-1:0]     push = '0, pop = '0;
  logic [NCH-1:0]    flush = '0;
  logic [QN*W-1:0]   wm_lo = '0, wm_hi = '0;
  logic [QN-1:0]     near_full, ovf_err, unf_err;
  logic [NCH-1:0]    ready, pause;

  always #2 clk = ~clk;

  fcw_flow_ctl #(.NUM_CH(NCH), .DEPTH(DEP), .WM_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .wm_lo(wm_lo), .wm_hi(wm_hi), .near_full(near_full), .ready(ready),
    .pause(pause), .ovf_err(ovf_err), .unf_err(unf_err));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string phase = "R1 reset";

  int mcnt [QN];
  bit mnf  [QN];
  bit movf [QN];
  bit munf [QN];
  bit mflq [NCH];

  task automatic chk(string req, int idx, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] idx %0d: actual %0d expected %0d", req, phase, idx, act, exp);
    end
  endtask

  task automatic set_wm(int i, int lo, int hi);
    wm_lo[i*W +: W] = W'(lo);
    wm_hi[i*W +: W] = W'(hi);
  endtask

  task automatic model_edge();
    for (int i = 0; i < QN; i++) begin
      int lo = int'(wm_lo[i*W +: W]);
      int hi = int'(wm_hi[i*W +: W]);
      if (flush[i/4]) begin
        mcnt[i] = 0; mnf[i] = 0; movf[i] = 0; munf[i] = 0;
      end else begin
        if (mcnt[i] >= hi)      mnf[i] = 1;
        else if (mcnt[i] <= lo) mnf[i] = 0;
        movf[i] = push[i] && !pop[i] && mcnt[i] == DEP;
        munf[i] = pop[i] && !push[i] && mcnt[i] == 0;
        if (push[i] && !pop[i] && mcnt[i] < DEP) mcnt[i]++;
        else if (pop[i] && !push[i] && mcnt[i] > 0) mcnt[i]--;
      end
    end
    for (int c = 0; c < NCH; c++) mflq[c] = flush[c];
  endtask

  task automatic compare();
    for (int i = 0; i < QN; i++) begin
      chk("R3 R4 near_full", i, int'(near_full[i]), int'(mnf[i]));
      chk("R7 ovf_err", i, int'(ovf_err[i]), int'(movf[i]));
      chk("R8 unf_err", i, int'(unf_err[i]), int'(munf[i]));
    end
    for (int c = 0; c < NCH; c++) begin
      chk("R5 R9 ready", c, int'(ready[c]), int'(!mflq[c] && !mnf[c*4+2] && !mnf[c*4+3]));
      chk("R6 pause", c, int'(pause[c]), int'(mnf[c*4] || mnf[c*4+1]));
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    push = '0; pop = '0;
  endtask

  task automatic fill_drain(int i, int lo, int hi);
    set_wm(i, lo, hi);
    for (int k = 0; k < DEP + 3; k++) begin push[i] = 1'b1; step(); end
    push[i] = 1'b1; pop[i] = 1'b1; step();
    for (int k = 0; k < DEP + 3; k++) begin pop[i] = 1'b1; step(); end
    push[i] = 1'b1; pop[i] = 1'b1; step();
    step(); step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < QN; i++) begin
      mcnt[i] = 0; mnf[i] = 0; movf[i] = 0; munf[i] = 0; set_wm(i, 4, 12);
    end
    for (int c = 0; c < NCH; c++) mflq[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare();
    step(); step();

    phase = "R2 R3 R4 R7 R8 sweep";
    for (int i = 0; i < QN; i++) begin
      fill_drain(i, 4, 12);
      fill_drain(i, 0, 16);
      fill_drain(i, 0, 1);
      fill_drain(i, 15, 16);
      fill_drain(i, 7, 7);
      fill_drain(i, 10, 3);
      fill_drain(i, 2, 0);
      set_wm(i, 4, 12);
    end

    phase = "R9 flush";
    for (int k = 0; k < 14; k++) begin push = '1; step(); end
    flush[0] = 1'b1;
    for (int k = 0; k < 3; k++) begin push = '1; step(); end
    flush[0] = 1'b0;
    step(); step();
    for (int k = 0; k < DEP + 2; k++) begin push[7:4] = '0; pop[3:0] = '1; pop[7:4] = '1; step(); end
    flush = '1; step(); flush = '0; step(); step();

    phase = "R10 mixed channels";
    lf = 16'hACE1;
    for (int i = 0; i < QN; i++) set_wm(i, 3 + i, 9 + i);
    for (int k = 0; k < 4000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      push = lf[7:0] | (k[9] ? 8'h00 : lf[15:8]);
      pop  = lf[15:8] & (k[8] ? lf[7:0] : 8'hFF);
      flush[0] = (lf[3:0] == 4'h0);
      flush[1] = (lf[11:8] == 4'hF) && k[4];
      step();
      flush = '0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule